// File: doc/BRIEF.md
# Multi-Type DRAM Burst Sequencer

This block paces four-beat cache-line bursts on a 64-bit memory data path. A requester presents a line read or a posted write, together with a memory kind (fast page mode, extended data out or synchronous DRAM) and an index that names one of six memory rows. Once the sequencer takes the request, it drives exactly one row-select line for the whole burst. It raises a data strobe on the clock of each of the four quadword beats and marks the last beat as burst completion.

Read bursts are spaced by memory kind. Synchronous DRAM reads run 6-1-1-1, extended-data-out reads run 5-2-2-2 and fast-page-mode reads run 6-3-3-3. Posted writes share one 3-1-1-1 pattern for every kind. The first number of a pattern is the lead-off. It counts clocks from the accepting edge to the edge that samples the first strobe. Each later number counts clocks from the previous strobe. The block carries no parity and does not multiplex device addresses.

Top module: `dram_burst_seq`

## Requirements
- R1: While reset is held, and after it is released with no request presented, `req_ready` is 1 and `row_sel`, `beat_stb` and `burst_done` are all 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next clock period up to and including the period of the fourth strobe, and it returns to 1 in the period after that.
- R3: For a read with `req_kind` = 2 (synchronous DRAM), the strobes fall in clock periods 6, 7, 8 and 9 after the accepting edge.
- R4: For a read with `req_kind` = 1 (extended data out), the strobes fall in periods 5, 7, 9 and 11.
- R5: For a read with `req_kind` = 0 (fast page mode), the strobes fall in periods 6, 9, 12 and 15. The reserved code 3 behaves the same way.
- R6: A write (`req_write` = 1) places its strobes in periods 3, 4, 5 and 6, whatever the value of `req_kind`.
- R7: While a burst is in progress, exactly one bit of `row_sel` is 1, namely bit `req_row` as captured at acceptance. An index of 6 or 7 selects bit 5.
- R8: While the sequencer is idle (`req_ready` = 1), `row_sel` is all zero and `beat_stb` is 0.
- R9: `beat_idx` numbers the strobes 0, 1, 2 and 3 in order. `burst_done` is 1 only in the period of the strobe with index 3.
- R10: While a burst is in progress, `req_valid` and any change on `req_write`, `req_kind` or `req_row` have no effect on the strobe timing or on `row_sel`.
- R11: A request held valid across the end of a burst is taken on the first edge on which `req_ready` is 1. Its row appears in the period after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A burst request is presented |
| req_write | input | 1 | 1 = posted write, 0 = line read |
| req_kind | input | 2 | Memory kind: 0 fast page, 1 extended data out, 2 synchronous, 3 reserved (same as 0) |
| req_row | input | 3 | Row index, 0 to 5; larger values clamp to 5 |
| req_ready | output | 1 | The sequencer can take a request |
| row_sel | output | 6 | One-hot row-select lines, active high |
| beat_stb | output | 1 | Data strobe for the current beat |
| beat_idx | output | 2 | Number of the current beat, meaningful with beat_stb |
| burst_done | output | 1 | Final beat of the burst |

## Verification
The hardest cases to reach from the ports are requests that arrive while a burst is running. One kind is a request pulsed mid-burst with a different kind and row. The other is a request held valid across the end of a burst, so that the edge where `req_ready` comes back is also the accepting edge. Directed bursts insert a one-period foreign request in the second period of a burst. Another directed sequence keeps `req_valid` high from one burst into the next. A random phase then mixes kinds, directions, out-of-range rows and idle gaps. Throughout, a behavioural model recomputes the beat schedule from the pattern table and compares it with the outputs on every clock.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [1:0] {
    MK_FAST_PAGE = 2'd0,
    MK_EXT_OUT   = 2'd1,
    MK_SYNC      = 2'd2,
    MK_RESERVED  = 2'd3
  } mem_kind_e;

  // Number of clock edges to wait before a strobe, expressed as a
  // countdown preload: a strobe appears when the counter reaches zero.
  function automatic int unsigned preload_of(input int unsigned spacing);
    return (spacing == 0) ? 0 : spacing - 1;
  endfunction

  // Last clock period (counted from the accepting edge) holding a strobe.
  function automatic int unsigned burst_span(input int unsigned lead,
                                             input int unsigned gap,
                                             input int unsigned beats);
    return lead + gap * (beats - 1);
  endfunction

endpackage

// File: rtl/dbs_timing.sv
module dbs_timing
  import dbs_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int WR_LEAD  = 3,
  parameter int WR_GAP   = 1,
  parameter int SYN_LEAD = 6,
  parameter int SYN_GAP  = 1,
  parameter int EXT_LEAD = 5,
  parameter int EXT_GAP  = 2,
  parameter int FPG_LEAD = 6,
  parameter int FPG_GAP  = 3
) (
  input  logic [1:0]       kind,
  input  logic             is_write,
  output logic [CNT_W-1:0] lead_pre,
  output logic [CNT_W-1:0] gap_pre
);

  localparam logic [CNT_W-1:0] WR_LEAD_P  = CNT_W'(preload_of(WR_LEAD));
  localparam logic [CNT_W-1:0] WR_GAP_P   = CNT_W'(preload_of(WR_GAP));
  localparam logic [CNT_W-1:0] SYN_LEAD_P = CNT_W'(preload_of(SYN_LEAD));
  localparam logic [CNT_W-1:0] SYN_GAP_P  = CNT_W'(preload_of(SYN_GAP));
  localparam logic [CNT_W-1:0] EXT_LEAD_P = CNT_W'(preload_of(EXT_LEAD));
  localparam logic [CNT_W-1:0] EXT_GAP_P  = CNT_W'(preload_of(EXT_GAP));
  localparam logic [CNT_W-1:0] FPG_LEAD_P = CNT_W'(preload_of(FPG_LEAD));
  localparam logic [CNT_W-1:0] FPG_GAP_P  = CNT_W'(preload_of(FPG_GAP));

  always_comb begin
    if (is_write) begin
      // Posted writes share one pattern across every memory kind.
      lead_pre = WR_LEAD_P;
      gap_pre  = WR_GAP_P;
    end else begin
      unique case (mem_kind_e'(kind))
        MK_SYNC: begin
          lead_pre = SYN_LEAD_P;
          gap_pre  = SYN_GAP_P;
        end
        MK_EXT_OUT: begin
          lead_pre = EXT_LEAD_P;
          gap_pre  = EXT_GAP_P;
        end
        default: begin
          lead_pre = FPG_LEAD_P;
          gap_pre  = FPG_GAP_P;
        end
      endcase
    end
  end

endmodule

// File: rtl/dbs_row_decode.sv
module dbs_row_decode #(
  parameter int NUM_ROWS = 6,
  parameter int IDX_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic [IDX_W-1:0]    idx,
  input  logic                enable,
  output logic [NUM_ROWS-1:0] sel
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_ROWS - 1);

  logic [IDX_W-1:0] idx_lim;

  // Indices beyond the last line fold onto the last line.
  assign idx_lim = (idx > TOP_IDX) ? TOP_IDX : idx;

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_line
    assign sel[g] = enable && (idx_lim == IDX_W'(g));
  end

endmodule

// File: rtl/dbs_beat_seq.sv
module dbs_beat_seq #(
  parameter int BEATS  = 4,
  parameter int CNT_W  = 4,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  lead_pre,
  input  logic [CNT_W-1:0]  gap_pre,
  output logic              busy,
  output logic              stb,
  output logic              last,
  output logic [BEAT_W-1:0] beat
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] gap_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign stb      = busy && cnt_zero;
  assign last     = stb && (beat == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      gap_q <= '0;
      beat  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= lead_pre;
      gap_q <= gap_pre;
      beat  <= '0;
    end else if (busy) begin
      if (cnt_zero) begin
        if (beat == LAST_BEAT) begin
          busy <= 1'b0;
        end else begin
          beat  <= beat + 1'b1;
          cnt_q <= gap_q;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R9: the beat number only moves forward by one per strobe within a burst
  a_r9_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stb && !last) |=> (beat == $past(beat) + 1'b1));

  // R2: a start is never taken while a burst is running
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
  import dbs_pkg::*;
#(
  parameter int NUM_ROWS = 6,
  parameter int BEATS    = 4,
  parameter int CNT_W    = 4,
  parameter int WR_LEAD  = 3,
  parameter int WR_GAP   = 1,
  parameter int SYN_LEAD = 6,
  parameter int SYN_GAP  = 1,
  parameter int EXT_LEAD = 5,
  parameter int EXT_GAP  = 2,
  parameter int FPG_LEAD = 6,
  parameter int FPG_GAP  = 3,
  localparam int IDX_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_kind,
  input  logic [IDX_W-1:0]    req_row,
  output logic                req_ready,
  output logic [NUM_ROWS-1:0] row_sel,
  output logic                beat_stb,
  output logic [BEAT_W-1:0]   beat_idx,
  output logic                burst_done
);

  // Named internal events, visible to the assertions below.
  logic             take;
  logic             busy;
  logic [CNT_W-1:0] lead_pre;
  logic [CNT_W-1:0] gap_pre;
  logic [IDX_W-1:0] row_q;

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;

  dbs_timing #(
    .CNT_W(CNT_W), .WR_LEAD(WR_LEAD), .WR_GAP(WR_GAP),
    .SYN_LEAD(SYN_LEAD), .SYN_GAP(SYN_GAP),
    .EXT_LEAD(EXT_LEAD), .EXT_GAP(EXT_GAP),
    .FPG_LEAD(FPG_LEAD), .FPG_GAP(FPG_GAP)
  ) u_timing (
    .kind     (req_kind),
    .is_write (req_write),
    .lead_pre (lead_pre),
    .gap_pre  (gap_pre)
  );

  dbs_beat_seq #(
    .BEATS(BEATS), .CNT_W(CNT_W), .BEAT_W(BEAT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (take),
    .lead_pre (lead_pre),
    .gap_pre  (gap_pre),
    .busy     (busy),
    .stb      (beat_stb),
    .last     (burst_done),
    .beat     (beat_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (take) begin
      row_q <= req_row;
    end
  end

  dbs_row_decode #(
    .NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W)
  ) u_rows (
    .idx    (row_q),
    .enable (busy),
    .sel    (row_sel)
  );

  // R2: acceptance drops ready in the following period
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);

  // R7: exactly one row line during a burst
  a_r7_one_row: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> $onehot(row_sel));

  // R8: idle means no row line and no strobe
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (row_sel == '0 && !beat_stb));

  // R9: completion coincides with the final strobe
  a_r9_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (beat_stb && beat_idx == BEAT_W'(BEATS - 1)));

  // R10: the row stays put for the whole burst
  a_r10_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(row_sel));

  // R2: ready returns right after completion
  a_r2_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> req_ready);

endmodule

// File: tb/dram_burst_seq_tb.sv
module dram_burst_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [2:0] req_row = 3'd0;
  logic       req_ready;
  logic [5:0] row_sel;
  logic       beat_stb;
  logic [1:0] beat_idx;
  logic       burst_done;

  int checks = 0;
  int failures = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  dram_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_kind(req_kind), .req_row(req_row), .req_ready(req_ready),
    .row_sel(row_sel), .beat_stb(beat_stb), .beat_idx(beat_idx),
    .burst_done(burst_done)
  );

  // Pattern table from the requirements (R3..R6).
  function automatic int lead_of(input bit wr, input int kind);
    if (wr) return 3;
    if (kind == 2) return 6;
    if (kind == 1) return 5;
    return 6;
  endfunction
  function automatic int gap_of(input bit wr, input int kind);
    if (wr) return 1;
    if (kind == 2) return 1;
    if (kind == 1) return 2;
    return 3;
  endfunction
  function automatic string tag_of(input bit wr, input int kind);
    if (wr) return "R6";
    if (kind == 2) return "R3";
    if (kind == 1) return "R4";
    return "R5";
  endfunction

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_busy = 1'b0;
  int m_el = 0, m_lead = 0, m_gap = 0, m_row = 0, m_kind = 0;
  bit m_wr = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0;
      m_el   = 0;
    end else if (m_busy) begin
      if (m_el == m_lead + 3 * m_gap) m_busy = 1'b0;
      else m_el++;
    end else if (req_valid) begin
      m_busy = 1'b1;
      m_el   = 1;
      m_wr   = req_write;
      m_kind = int'(req_kind);
      m_lead = lead_of(req_write, int'(req_kind));
      m_gap  = gap_of(req_write, int'(req_kind));
      m_row  = (req_row > 3'd5) ? 5 : int'(req_row);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      int d;
      bit e_stb;
      int e_rows;
      d      = m_el - m_lead;
      e_stb  = m_busy && d >= 0 && (d % m_gap) == 0 && (d / m_gap) < 4;
      e_rows = m_busy ? (1 << m_row) : 0;
      check("R2", "ready", int'(req_ready), int'(!m_busy));
      check(m_busy ? "R7" : "R8", "row_sel", int'(row_sel), e_rows);
      check(m_busy ? tag_of(m_wr, m_kind) : "R8", "beat_stb", int'(beat_stb), int'(e_stb));
      if (e_stb) check("R9", "beat_idx", int'(beat_idx), d / m_gap);
      check("R9", "burst_done", int'(burst_done), int'(e_stb && (d / m_gap) == 3));
    end
  end

  // One burst from an idle sequencer; optionally disturbs the inputs mid-burst.
  task automatic run_burst(input bit wr, input int kind, input int row, input bit disturb);
    int n;
    int exp_row;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_kind = 2'(kind); req_row = 3'(row);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    exp_row = (row > 5) ? 5 : row;
    check("R7", "row at start", int'(row_sel), 1 << exp_row);
    while (!burst_done) begin
      if (disturb && n == 2) begin
        // R10: foreign request while busy
        req_valid = 1'b1; req_write = ~wr; req_kind = ~2'(kind); req_row = 3'(row ^ 1);
      end else if (disturb && n == 3) begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    check(disturb ? "R10" : tag_of(wr, kind), "last strobe period", n,
          lead_of(wr, kind) + 3 * gap_of(wr, kind));
    if (disturb) check("R10", "row held", int'(row_sel), 1 << exp_row);
    @(negedge clk);
    check("R2", "ready after burst", int'(req_ready), 1);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1", "ready in reset", int'(req_ready), 1);
    check("R1", "rows in reset", int'(row_sel), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "ready idle", int'(req_ready), 1);
    check("R1", "strobe idle", int'(beat_stb), 0);
    check("R1", "done idle", int'(burst_done), 0);

    // Every kind, both directions (R3, R4, R5, R6)
    for (int k = 0; k < 4; k++) begin
      run_burst(1'b0, k, k, 1'b0);
      run_burst(1'b1, k, 5 - k, 1'b0);
    end
    // R7: clamp of out-of-range indices
    run_burst(1'b0, 2, 6, 1'b0);
    run_burst(1'b1, 1, 7, 1'b0);
    // R10: mid-burst disturbance
    run_burst(1'b0, 0, 3, 1'b1);
    run_burst(1'b1, 2, 1, 1'b1);

    // R11: request held across the end of a burst
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_kind = 2'd2; req_row = 3'd2;
    @(negedge clk);
    req_write = 1'b1; req_kind = 2'd1; req_row = 3'd4;
    while (!burst_done) @(negedge clk);
    @(negedge clk);
    check("R11", "ready gap", int'(req_ready), 1);
    @(negedge clk);
    check("R11", "held request taken", int'(req_ready), 0);
    check("R11", "new row", int'(row_sel), 1 << 4);
    req_valid = 1'b0;
    while (!burst_done) @(negedge clk);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      run_burst(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule